// File: doc/BRIEF.md
# Address-Filtering Asynchronous Serial Receiver

This block receives asynchronous serial frames from a line shared by several nodes. Every frame carries one extra flag bit after the data byte (and after the optional parity bit). A flag value of 1 marks an address frame and 0 marks a payload frame. The receiver holds a programmable node address. When an address frame names this node, the receiver selects itself and passes the payload frames that follow to the host. When an address frame names another node, it deselects itself and drops payload frames until the next address frame.

The line is sampled through a synchronizer on a clock-enable `tick` that runs at an oversampling multiple of the bit rate. Start bits are confirmed at mid-bit. Each delivered byte sits in a holding register with a full flag that the host clears with a one-cycle read acknowledge. Framing, parity and overrun conditions set sticky flags and pulse an error request. A separate clear input resets the error flags.

Top module: `mpf_uart_rx`

## Requirements
- R1: The idle line is high. A low level seen on a tick starts a frame only if it still reads 0 when sampled at mid-bit (OVS/2 ticks later). A start that reads 1 there is dropped: no request, and all outputs stay unchanged.
- R2: Bits are sampled every OVS ticks in this order: data bits least significant first, then the parity bit if `par_en` was 1 at the start bit, then the flag bit, then the stop bit.
- R3: A clean frame with flag bit 1 is compared with `local_id`. A match drives `selected` to 1. The address byte is never written to `rx_data`, and it raises neither `rx_req` nor `err_req`.
- R4: A clean address frame that does not match drives `selected` to 0. While `selected` is 0, clean frames with flag bit 0 are dropped: `rx_full`, `rx_data` and both requests stay unchanged.
- R5: While `selected` is 1 and `rx_full` is 0, a clean frame with flag bit 0 loads `rx_data`, sets `rx_full` and pulses `rx_req` for one cycle.
- R6: A one-cycle `rd_ack` clears `rx_full`.
- R7: A stop bit sampled as 0 sets `frame_err` and pulses `err_req`. The frame is not delivered and `selected` is unchanged.
- R8: With parity enabled, the expected parity bit is the XOR of the data bits when `par_odd` is 0, and its inverse when `par_odd` is 1. A mismatch sets `par_err`, pulses `err_req` and drops the frame, leaving `selected` unchanged. With parity disabled, no parity slot exists.
- R9: A frame that would be delivered while `rx_full` is 1 sets `overrun` and pulses `err_req`. `rx_data` keeps the older byte.
- R10: Reset clears `selected`, `rx_full`, `rx_data` and all error flags. A one-cycle `flag_clr` clears `frame_err`, `par_err` and `overrun`.
- R11: `rx_req` and `err_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling clock enable, OVS ticks per bit |
| rxd | input | 1 | Serial line input |
| par_en | input | 1 | Parity slot present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| local_id | input | DATA_W | Address of this node |
| rd_ack | input | 1 | Host read acknowledge, clears rx_full |
| flag_clr | input | 1 | Clears the three error flags |
| rx_data | output | DATA_W | Last delivered byte |
| rx_full | output | 1 | Holding register full |
| rx_req | output | 1 | One-cycle receive request |
| err_req | output | 1 | One-cycle error request |
| frame_err | output | 1 | Sticky framing error |
| par_err | output | 1 | Sticky parity error |
| overrun | output | 1 | Sticky overrun |
| selected | output | 1 | Node currently addressed |

## Verification
The bench builds the block with OVS = 8, DATA_W = 8, two synchronizer stages and parity support present. The bench drives `tick` on every second clock, so a bit lasts 16 clocks and mid-bit sampling has a two-clock margin. These settings make it cheap to run long random mixes of address and payload frames, parity on and off in both senses, corrupted parity and stop bits, and read acknowledges left out to force overruns. Short low glitches on the line test start rejection. A reset asserted mid-session tests the return to the deselected state.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_SHIFT = 2'd2
   } rx_state_e;
endpackage

// File: rtl/mpf_sync.sv
module mpf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b1;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_multi
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '1;
            else        r <= {r[STAGES-2:0], d};
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mpf_deframer.sv
module mpf_deframer
   import mpf_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter bit PAR_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxs,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              fr_done,
   output logic [DATA_W-1:0] fr_data,
   output logic              fr_mp,
   output logic              fr_stop_ok,
   output logic              fr_par_ok
);
   localparam int CNT_W = $clog2(OVS);
   localparam int BIT_W = $clog2(DATA_W + 4);
   localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVS - 1);
   localparam logic [BIT_W-1:0] DW_B    = BIT_W'(DATA_W);

   rx_state_e         st;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bitn;
   logic [BIT_W-1:0]  mp_idx;
   logic [BIT_W-1:0]  stop_idx;
   logic [DATA_W-1:0] data_sh;
   logic              par_bit;
   logic              mp_bit;
   logic              par_on;
   logic              par_on_q;
   logic              par_odd_q;

   generate
      if (PAR_SUPPORT) begin : g_par
         assign par_on = par_en;
      end else begin : g_nopar
         logic unused_par;
         assign unused_par = par_en;
         assign par_on     = 1'b0;
      end
   endgenerate

   assign mp_idx   = DW_B + {{(BIT_W-1){1'b0}}, par_on_q};
   assign stop_idx = mp_idx + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= RX_IDLE;
         cnt        <= '0;
         bitn       <= '0;
         data_sh    <= '0;
         par_bit    <= 1'b0;
         mp_bit     <= 1'b0;
         par_on_q   <= 1'b0;
         par_odd_q  <= 1'b0;
         fr_done    <= 1'b0;
         fr_data    <= '0;
         fr_mp      <= 1'b0;
         fr_stop_ok <= 1'b0;
         fr_par_ok  <= 1'b0;
      end else begin
         fr_done <= 1'b0;
         if (tick) begin
            unique case (st)
               RX_IDLE: begin
                  if (!rxs) begin
                     st        <= RX_START;
                     cnt       <= '0;
                     par_on_q  <= par_on;
                     par_odd_q <= par_odd;
                  end
               end
               RX_START: begin
                  if (cnt == HALF_M1) begin
                     cnt  <= '0;
                     bitn <= '0;
                     st   <= rxs ? RX_IDLE : RX_SHIFT;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_SHIFT: begin
                  if (cnt == FULL_M1) begin
                     cnt  <= '0;
                     bitn <= bitn + 1'b1;
                     if (bitn < DW_B) begin
                        data_sh <= {rxs, data_sh[DATA_W-1:1]};
                     end else if (bitn == mp_idx) begin
                        mp_bit <= rxs;
                     end else if (bitn == stop_idx) begin
                        fr_done    <= 1'b1;
                        fr_data    <= data_sh;
                        fr_mp      <= mp_bit;
                        fr_stop_ok <= rxs;
                        fr_par_ok  <= !par_on_q ||
                                      (par_bit == ((^data_sh) ^ par_odd_q));
                        st         <= RX_IDLE;
                     end else begin
                        par_bit <= rxs;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/mpf_addr_filter.sv
module mpf_addr_filter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fr_done,
   input  logic [DATA_W-1:0] fr_data,
   input  logic              fr_mp,
   input  logic              fr_stop_ok,
   input  logic              fr_par_ok,
   input  logic [DATA_W-1:0] local_id,
   input  logic              rd_ack,
   input  logic              flag_clr,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              rx_req,
   output logic              err_req,
   output logic              frame_err,
   output logic              par_err,
   output logic              overrun,
   output logic              selected
);
   logic full_eff;
   assign full_eff = rx_full && !rd_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data   <= '0;
         rx_full   <= 1'b0;
         rx_req    <= 1'b0;
         err_req   <= 1'b0;
         frame_err <= 1'b0;
         par_err   <= 1'b0;
         overrun   <= 1'b0;
         selected  <= 1'b0;
      end else begin
         rx_req  <= 1'b0;
         err_req <= 1'b0;
         if (rd_ack) rx_full <= 1'b0;
         if (flag_clr) begin
            frame_err <= 1'b0;
            par_err   <= 1'b0;
            overrun   <= 1'b0;
         end
         if (fr_done) begin
            if (!fr_stop_ok) begin
               frame_err <= 1'b1;
               err_req   <= 1'b1;
            end else if (!fr_par_ok) begin
               par_err <= 1'b1;
               err_req <= 1'b1;
            end else if (fr_mp) begin
               selected <= (fr_data == local_id);
            end else if (selected) begin
               if (full_eff) begin
                  overrun <= 1'b1;
                  err_req <= 1'b1;
               end else begin
                  rx_data <= fr_data;
                  rx_full <= 1'b1;
                  rx_req  <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/mpf_uart_rx.sv
module mpf_uart_rx #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit PAR_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic [DATA_W-1:0] local_id,
   input  logic              rd_ack,
   input  logic              flag_clr,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              rx_req,
   output logic              err_req,
   output logic              frame_err,
   output logic              par_err,
   output logic              overrun,
   output logic              selected
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("mpf_uart_rx: OVS must be even and at least 4");
      end
      if (DATA_W < 4) begin : g_bad_dw
         $error("mpf_uart_rx: DATA_W must be at least 4");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("mpf_uart_rx: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic              rxs;
   logic              fr_done;
   logic [DATA_W-1:0] fr_data;
   logic              fr_mp;
   logic              fr_stop_ok;
   logic              fr_par_ok;

   mpf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rxd),
      .q     (rxs)
   );

   mpf_deframer #(
      .DATA_W      (DATA_W),
      .OVS         (OVS),
      .PAR_SUPPORT (PAR_SUPPORT)
   ) u_deframer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .rxs        (rxs),
      .par_en     (par_en),
      .par_odd    (par_odd),
      .fr_done    (fr_done),
      .fr_data    (fr_data),
      .fr_mp      (fr_mp),
      .fr_stop_ok (fr_stop_ok),
      .fr_par_ok  (fr_par_ok)
   );

   mpf_addr_filter #(.DATA_W(DATA_W)) u_filter (
      .clk        (clk),
      .rst_n      (rst_n),
      .fr_done    (fr_done),
      .fr_data    (fr_data),
      .fr_mp      (fr_mp),
      .fr_stop_ok (fr_stop_ok),
      .fr_par_ok  (fr_par_ok),
      .local_id   (local_id),
      .rd_ack     (rd_ack),
      .flag_clr   (flag_clr),
      .rx_data    (rx_data),
      .rx_full    (rx_full),
      .rx_req     (rx_req),
      .err_req    (err_req),
      .frame_err  (frame_err),
      .par_err    (par_err),
      .overrun    (overrun),
      .selected   (selected)
   );
endmodule

// File: rtl/mpf_uart_rx_chk.sv
module mpf_uart_rx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_ack,
   input logic [DATA_W-1:0] local_id,
   input logic              fr_done,
   input logic [DATA_W-1:0] fr_data,
   input logic              fr_mp,
   input logic              fr_stop_ok,
   input logic              fr_par_ok,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_full,
   input logic              rx_req,
   input logic              err_req,
   input logic              frame_err,
   input logic              overrun,
   input logic              selected
);
   logic clean;
   assign clean = fr_done && fr_stop_ok && fr_par_ok;

   // R3
   a_r3_match_selects: assert property (@(posedge clk) disable iff (!rst_n)
      clean && fr_mp && (fr_data == local_id) |=> selected && !rx_req && !err_req);

   // R4
   a_r4_mismatch_deselects: assert property (@(posedge clk) disable iff (!rst_n)
      clean && fr_mp && (fr_data != local_id) |=> !selected && !rx_req);

   a_r4_discard: assert property (@(posedge clk) disable iff (!rst_n)
      clean && !fr_mp && !selected |=> !rx_req && !err_req && $stable(rx_data));

   // R5
   a_r5_deliver: assert property (@(posedge clk) disable iff (!rst_n)
      clean && !fr_mp && selected && (!rx_full || rd_ack)
      |=> rx_req && rx_full && (rx_data == $past(fr_data)));

   // R6
   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack && !fr_done |=> !rx_full);

   // R7
   a_r7_frame_err: assert property (@(posedge clk) disable iff (!rst_n)
      fr_done && !fr_stop_ok |=> frame_err && err_req && !rx_req && $stable(selected));

   // R9
   a_r9_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      clean && !fr_mp && selected && rx_full && !rd_ack
      |=> overrun && err_req && $stable(rx_data));

   a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full && !rd_ack |=> rx_full && $stable(rx_data));

   // R11
   a_r11_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_req && err_req));
endmodule

bind mpf_uart_rx mpf_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_ack     (rd_ack),
   .local_id   (local_id),
   .fr_done    (fr_done),
   .fr_data    (fr_data),
   .fr_mp      (fr_mp),
   .fr_stop_ok (fr_stop_ok),
   .fr_par_ok  (fr_par_ok),
   .rx_data    (rx_data),
   .rx_full    (rx_full),
   .rx_req     (rx_req),
   .err_req    (err_req),
   .frame_err  (frame_err),
   .overrun    (overrun),
   .selected   (selected)
);

// File: tb/test_mpf_uart_rx.sv
module test_mpf_uart_rx;
   localparam int CLK_PERIOD = 10;
   localparam int DW         = 8;
   localparam int OVS        = 8;
   localparam int TDIV       = 2;
   localparam int BIT        = OVS * TDIV;
   localparam int WDOG       = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          rxd = 1'b1;
   logic          par_en = 1'b0;
   logic          par_odd = 1'b0;
   logic [DW-1:0] local_id = 8'h5A;
   logic          rd_ack = 1'b0;
   logic          flag_clr = 1'b0;
   logic [DW-1:0] rx_data;
   logic          rx_full, rx_req, err_req, frame_err, par_err, overrun, selected;

   int checks = 0;
   int fails = 0;
   int n_req = 0, n_err = 0;
   int e_req = 0, e_err = 0;
   int tdc = 0;
   bit e_sel = 0, e_full = 0, e_fe = 0, e_pe = 0, e_ov = 0;
   logic [DW-1:0] e_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mpf_uart_rx #(.DATA_W(DW), .OVS(OVS), .SYNC_STAGES(2), .PAR_SUPPORT(1'b1)) i_mpf_uart_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .par_en(par_en),
      .par_odd(par_odd), .local_id(local_id), .rd_ack(rd_ack), .flag_clr(flag_clr),
      .rx_data(rx_data), .rx_full(rx_full), .rx_req(rx_req), .err_req(err_req),
      .frame_err(frame_err), .par_err(par_err), .overrun(overrun), .selected(selected)
   );

   always @(negedge clk) begin
      tdc  = (tdc + 1) % TDIV;
      tick = (tdc == 0);
      if (!rst_n) begin
         n_req = 0;
         n_err = 0;
      end else begin
         if (rx_req)  n_req++;
         if (err_req) n_err++;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      check({tag, " R3/R4 selected"}, int'(selected), int'(e_sel));
      check({tag, " R5/R6 rx_full"}, int'(rx_full), int'(e_full));
      check({tag, " R5/R9 rx_data"}, int'(rx_data), int'(e_data));
      check({tag, " R7 frame_err"}, int'(frame_err), int'(e_fe));
      check({tag, " R8 par_err"}, int'(par_err), int'(e_pe));
      check({tag, " R9 overrun"}, int'(overrun), int'(e_ov));
      check({tag, " R5 rx_req count"}, n_req, e_req);
      check({tag, " R11 err_req count"}, n_err, e_err);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      rxd   = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      e_sel = 0; e_full = 0; e_fe = 0; e_pe = 0; e_ov = 0;
      e_data = '0; e_req = 0; e_err = 0;
      @(negedge clk);
   endtask

   task automatic send_bit(input bit b);
      rxd = b;
      repeat (BIT) @(negedge clk);
   endtask

   task automatic ack();
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
      e_full = 0;
   endtask

   task automatic clr();
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      e_fe = 0; e_pe = 0; e_ov = 0;
   endtask

   function automatic bit par_of(input logic [DW-1:0] d, input bit odd);
      return (^d) ^ odd;
   endfunction

   // reference model of the filter from the requirements
   task automatic model(input logic [DW-1:0] d, input bit mp, input bit bad_par, input bit bad_stop);
      if (bad_stop) begin
         e_fe = 1; e_err++;
      end else if (par_en && bad_par) begin
         e_pe = 1; e_err++;
      end else if (mp) begin
         e_sel = (d == local_id);
      end else if (e_sel) begin
         if (e_full) begin
            e_ov = 1; e_err++;
         end else begin
            e_data = d; e_full = 1; e_req++;
         end
      end
   endtask

   task automatic frame(input logic [DW-1:0] d, input bit mp, input bit bad_par, input bit bad_stop);
      send_bit(1'b0);
      for (int i = 0; i < DW; i++) send_bit(d[i]);
      if (par_en) send_bit(par_of(d, par_odd) ^ bad_par);
      send_bit(mp);
      send_bit(!bad_stop);
      send_bit(1'b1);
      send_bit(1'b1);
      model(d, mp, bad_par, bad_stop);
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog: actual %0d cycles expected completion", WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      do_reset();
      check_all("reset R10");

      // R4: payload before any address is dropped
      frame(8'hC3, 1'b0, 1'b0, 1'b0);
      check_all("pre-address R4");

      // R3: matching address, not delivered
      frame(8'h5A, 1'b1, 1'b0, 1'b0);
      check_all("address match R3");

      // R2/R5: LSB-first payload, no parity
      frame(8'h81, 1'b0, 1'b0, 1'b0);
      check_all("payload R2 R5");
      ack();
      check_all("ack R6");

      // R9: overrun keeps old data
      frame(8'h3C, 1'b0, 1'b0, 1'b0);
      frame(8'hE7, 1'b0, 1'b0, 1'b0);
      check_all("overrun R9");
      clr();
      ack();
      check_all("flag_clr R10");

      // R7: framing error, selection kept
      frame(8'h11, 1'b0, 1'b0, 1'b1);
      check_all("bad stop R7");
      frame(8'h22, 1'b0, 1'b0, 1'b0);
      check_all("after frame error R7");
      ack();

      // R8: even then odd parity, good and bad
      par_en = 1'b1; par_odd = 1'b0;
      frame(8'h07, 1'b0, 1'b0, 1'b0);
      check_all("even parity R8");
      ack();
      frame(8'h07, 1'b0, 1'b1, 1'b0);
      check_all("even parity bad R8");
      par_odd = 1'b1;
      frame(8'hF0, 1'b0, 1'b0, 1'b0);
      check_all("odd parity R8");
      ack();
      frame(8'hF0, 1'b1, 1'b1, 1'b0);
      check_all("odd parity bad address R8");
      clr();

      // R1: glitch shorter than half a bit is rejected
      rxd = 1'b0;
      repeat (BIT/2 - 4) @(negedge clk);
      rxd = 1'b1;
      repeat (3*BIT) @(negedge clk);
      check_all("glitch R1");
      frame(8'h99, 1'b0, 1'b0, 1'b0);
      check_all("after glitch R1");
      ack();

      // R4: mismatching address, then payload dropped
      par_en = 1'b0;
      frame(8'h5B, 1'b1, 1'b0, 1'b0);
      check_all("address mismatch R4");
      frame(8'h44, 1'b0, 1'b0, 1'b0);
      check_all("dropped payload R4");

      // random mix
      for (int n = 0; n < 90; n++) begin
         logic [DW-1:0] d;
         bit mp, bp, bs;
         if (n % 15 == 0) begin
            par_en  = $urandom_range(0, 1);
            par_odd = $urandom_range(0, 1);
            local_id = DW'($urandom);
         end
         mp = ($urandom_range(0, 9) < 3);
         d  = (mp && $urandom_range(0, 1)) ? local_id : DW'($urandom);
         bp = ($urandom_range(0, 9) == 0);
         bs = ($urandom_range(0, 11) == 0);
         if ($urandom_range(0, 9) < 6) ack();
         if ($urandom_range(0, 9) == 0) clr();
         frame(d, mp, bp, bs);
         check_all("random R2 R3 R4 R5 R7 R8 R9");
      end

      // R10: reset while selected
      frame(local_id, 1'b1, 1'b0, 1'b0);
      frame(8'h6D, 1'b0, 1'b0, 1'b0);
      do_reset();
      check_all("mid-session reset R10");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule